// File: doc/BRIEF.md
# Unaligned Read Access Unit

This block sits between a requester that asks for a byte, a halfword or a word at any byte address and a memory that can only return whole, aligned 32-bit words. It converts each request into word reads. The word address is the byte address with its two low bits removed. The block returns the requested bytes right-justified, with the lowest-addressed byte in the least significant position.

A request that stays inside one aligned word costs one memory read. A request that crosses into the next word costs two reads, issued on consecutive cycles. The first returned word is shifted down by the byte offset. The second is shifted up by the bytes already collected, and the two are ORed together. While an access is in flight the requester sees ready low. A saturating counter of issued memory reads makes the one-read versus two-read cost of each access visible.

Top module: `unaligned_rd_unit`

## Requirements
- R1: In the cycle after a request is accepted (req_valid and req_ready high at a clock edge), mem_rd_en is high and mem_addr equals req_addr with its two low bits dropped.
- R2: A request whose bytes all fit in one aligned word, that is (req_addr[1:0] + size in bytes) <= 4, issues exactly one memory read.
- R3: A request with (req_addr[1:0] + size in bytes) > 4 issues exactly two reads on consecutive cycles. The second read targets the first word address plus one.
- R4: req_size 2'b00 selects one byte, 2'b01 two bytes, 2'b10 four bytes, and 2'b11 is handled as four bytes. The result is little-endian and right-justified, and bits above the requested size are zero.
- R5: For a straddling request, the low part of the result comes from the first word, shifted down by 8*offset bits. The remaining bytes come from the second word, shifted up by 8*(4-offset) bits, and the two parts are ORed.
- R6: req_ready is high whenever no access is in flight. It is low from the cycle after acceptance through the cycle that carries the response.
- R7: rsp_valid is a one-cycle pulse in the cycle after the last read data returns. That is two cycles after the accepting edge for a single-read access and three cycles after it for a split access.
- R8: rd_count increments by one for every cycle with mem_rd_en high and holds at its all-ones value once it gets there.
- R9: During and right after reset, req_ready is 1, and rsp_valid, mem_rd_en and rd_count are 0.
- R10: rsp_data is zero in every cycle in which rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Right-justified result |
| mem_rd_en | output | 1 | Word read strobe to memory |
| mem_addr | output | ADDR_W-2 | Word address of the read |
| mem_rdata | input | 32 | Word returned one cycle after mem_rd_en |
| rd_count | output | CNT_W | Saturating count of reads issued |

## Verification
The first read is due one cycle after the accepting edge. Data for a single-read access returns one cycle after that, and rsp_valid follows two cycles after acceptance. A split access puts its second read in the next cycle and responds three cycles after acceptance. The bench stamps each accepted request with a cycle number and checks the response against that stamp. It tallies the read strobes between responses and checks each strobe's word address while the access is in flight. All sampling happens on the falling edge, half a period after the registers settle.

// File: rtl/uar_pkg.sv
// Shared encodings for the unaligned read unit.
// Assumes a fixed 32-bit memory word (four byte lanes).
package uar_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_DAT1,
        ST_DAT2,
        ST_RESP
    } state_e;

    // Number of bytes selected by a size code; code 3 counts as a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/uar_plan.sv
// Access planner: splits a byte address into word address and lane
// offset, works out whether the access crosses a word boundary and
// builds the result mask. Purely combinational.
module uar_plan
    import uar_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [WA_W-1:0]   word_addr,
    output logic [1:0]        offset,
    output logic              straddle,
    output logic [31:0]       keep_mask
);
    logic [2:0] nbytes;
    logic [3:0] end_lane;

    // Decode lane geometry of the access.
    always_comb begin
        word_addr = addr[ADDR_W-1:2];
        offset    = addr[1:0];
        nbytes    = size_bytes(size);
        end_lane  = {2'b00, addr[1:0]} + {1'b0, nbytes};
        straddle  = end_lane > 4'd4;
    end

    // One mask byte per requested lane, generated per lane.
    for (genvar g = 0; g < 4; g++) begin : g_mask
        assign keep_mask[8*g +: 8] = (g < int'(nbytes)) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/uar_merge.sv
// Merge datapath: loads the first word shifted down by the lane offset,
// ORs in the second word shifted up by the bytes already held, and masks
// the result to the access size. Assumes load_hi only follows load_lo.
module uar_merge (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_lo,
    input  logic        load_hi,
    input  logic [1:0]  offset,
    input  logic [31:0] keep_mask,
    input  logic [31:0] rdata,
    output logic [31:0] merged
);
    logic [31:0] acc;
    logic [5:0]  lo_shift;
    logic [5:0]  hi_shift;

    // Shift amounts in bits for the two halves.
    always_comb begin
        lo_shift = {offset, 3'b000};
        hi_shift = 6'd32 - {offset, 3'b000};
    end

    // Accumulator update for first and second word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load_lo) begin
            acc <= rdata >> lo_shift;
        end else if (load_hi) begin
            acc <= acc | (rdata << hi_shift);
        end
    end

    // Drop bytes beyond the requested size.
    assign merged = acc & keep_mask;

endmodule

// File: rtl/uar_rdcount.sv
// Saturating event counter for issued memory reads.
module uar_rdcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count up and hold at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/unaligned_rd_unit.sv
// Unaligned read unit top. Accepts one request at a time, issues one or
// two aligned word reads to a memory with one-cycle read latency, merges
// the bytes and pulses rsp_valid once. Assumes the memory always answers
// exactly one cycle after each mem_rd_en.
module unaligned_rd_unit
    import uar_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    localparam int WA_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              mem_rd_en,
    output logic [WA_W-1:0]   mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic [CNT_W-1:0]  rd_count
);
    state_e            state, state_nx;
    logic [ADDR_W-1:0] r_addr;
    logic [1:0]        r_size;
    logic [WA_W-1:0]   p_word;
    logic [1:0]        p_off;
    logic              p_split;
    logic [31:0]       p_mask;
    logic [31:0]       merged;
    logic              accept;

    assign accept = req_valid && req_ready;

    uar_plan #(.ADDR_W(ADDR_W)) u_plan (
        .addr      (r_addr),
        .size      (r_size),
        .word_addr (p_word),
        .offset    (p_off),
        .straddle  (p_split),
        .keep_mask (p_mask)
    );

    uar_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_lo   (state == ST_DAT1),
        .load_hi   (state == ST_DAT2),
        .offset    (p_off),
        .keep_mask (p_mask),
        .rdata     (mem_rdata),
        .merged    (merged)
    );

    uar_rdcount #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mem_rd_en),
        .count (rd_count)
    );

    // Capture the request at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr <= '0;
            r_size <= '0;
        end else if (accept) begin
            r_addr <= req_addr;
            r_size <= req_size;
        end
    end

    // Sequencer next state.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (accept) state_nx = ST_RD1;
            ST_RD1:  state_nx = ST_DAT1;
            ST_DAT1: state_nx = p_split ? ST_DAT2 : ST_RESP;
            ST_DAT2: state_nx = ST_RESP;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Memory read strobes: first word, then the next word on a split.
    always_comb begin
        mem_rd_en = (state == ST_RD1) || ((state == ST_DAT1) && p_split);
        mem_addr  = (state == ST_DAT1) ? p_word + 1'b1 : p_word;
    end

    // Requester-side outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_data  = rsp_valid ? merged : 32'h0;
    end

endmodule

// Protocol checker for the unaligned read unit, port-level only.
module uar_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    localparam int WA_W  = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_data,
    input logic              mem_rd_en,
    input logic [WA_W-1:0]   mem_addr,
    input logic [CNT_W-1:0]  rd_count
);
    a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_rd_en && (mem_addr == $past(req_addr[ADDR_W-1:2])));

    a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |-> mem_addr == $past(mem_addr) + 1'b1);

    a_r3_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && $past(mem_rd_en) |=> !mem_rd_en);

    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r6_busy_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_en) && ($past(rd_count) != '1) |-> rd_count == $past(rd_count) + 1'b1);

    a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_rd_en) |-> $stable(rd_count));

    a_r10_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_data == 32'h0);
endmodule

bind unaligned_rd_unit uar_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .rd_count  (rd_count)
);

// File: tb/tb_unaligned_rd_unit.sv
`timescale 1ns/1ps
module tb_unaligned_rd_unit;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          mem_rd_en;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic [CW-1:0] rd_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        int            nrd;
        int            acc_cyc;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    unaligned_rd_unit #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .rd_count(rd_count)
    );

    // Content of each memory byte, derived from its address.
    function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'd11;
        return t[7:0] ^ a[15:8];
    endfunction

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en)
            for (int i = 0; i < 4; i++)
                mem_rdata[8*i +: 8] <= mbyte({mem_addr, 2'(i)});
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: issue one request and push its expected outcome.
    task automatic drive(input logic [AW-1:0] a, input logic [1:0] s);
        exp_t e;
        int   nb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = s;
        @(posedge clk);
        #1;
        nb = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
        e.addr = a;
        e.data = '0;
        for (int i = 0; i < nb; i++) e.data[8*i +: 8] = mbyte(a + AW'(i));
        e.nrd = (int'(a[1:0]) + nb > 4) ? 2 : 1;
        e.acc_cyc = cyc;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares responses, read strobes, latency and counter.
    int  rd_seen  = 0;
    int  exp_cnt  = 0;
    bit  prev_rsp = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rsp) check(req_ready == 1'b1, "R6 ready after rsp", 32'(req_ready), 32'd1);
            prev_rsp = rsp_valid;
            if (mem_rd_en) begin
                if (sb.size() == 0) check(1'b0, "R1 read without request", 32'(mem_addr), 0);
                else if (rd_seen == 0)
                    check(mem_addr == sb[0].addr[AW-1:2], "R1 first word address",
                          32'(mem_addr), 32'(sb[0].addr[AW-1:2]));
                else
                    check(mem_addr == sb[0].addr[AW-1:2] + 1'b1, "R3 second word address",
                          32'(mem_addr), 32'(sb[0].addr[AW-1:2] + 1'b1));
                rd_seen++;
            end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 unexpected response", rsp_data, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_data == e.data, (e.nrd == 2) ? "R5 merged data" : "R4 data",
                          rsp_data, e.data);
                    check(rd_seen == e.nrd, (e.nrd == 2) ? "R3 two reads" : "R2 one read",
                          32'(rd_seen), 32'(e.nrd));
                    check(cyc - e.acc_cyc == e.nrd + 1, "R7 response latency",
                          32'(cyc - e.acc_cyc), 32'(e.nrd + 1));
                    check(req_ready == 1'b0, "R6 ready low at rsp", 32'(req_ready), 0);
                    exp_cnt = (exp_cnt + e.nrd > CMAX) ? CMAX : exp_cnt + e.nrd;
                    check(rd_count == CW'(exp_cnt), "R8 read counter",
                          32'(rd_count), 32'(exp_cnt));
                end
                rd_seen = 0;
            end else begin
                check(rsp_data == 32'h0, "R10 data zero when idle", rsp_data, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    logic [31:0] lcg = 32'h1234_5678;
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R9 reset mem_rd_en", 32'(mem_rd_en), 0);
        check(rd_count == '0, "R9 reset count", 32'(rd_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rd_count == '0, "R9 after reset", 32'(rd_count), 0);
        // Directed corner cases
        drive(16'h0005, 2'b01);  // R2 half at offset 1
        drive(16'h0001, 2'b10);  // R5 word at offset 1, split
        drive(16'h0003, 2'b00);  // R4 byte at top lane
        drive(16'h0003, 2'b01);  // R3 half split
        drive(16'h0002, 2'b01);  // R2 half fits
        drive(16'h0004, 2'b10);  // R2 aligned word
        drive(16'h0006, 2'b11);  // R4 code 3 as word, split
        drive(16'h0007, 2'b10);  // R5 offset 3
        drive(16'hFFFE, 2'b10);  // R3 wrap at top of space
        // Pseudo-random mix, enough reads to saturate the counter (R8)
        for (int k = 0; k < 220; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            drive(lcg[23:8], lcg[29:28]);
        end
        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R7 all responses seen", 32'(sb.size()), 0);
        check(rd_count == CW'(CMAX), "R8 saturated", 32'(rd_count), 32'(CMAX));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule